// File: doc/BRIEF.md
# Four-Lane Stream Cipher Keystream Generator

This block computes the 20-round ARX stream-cipher block function (the ChaCha20 construction) for four neighbouring block counters at once. A caller presents a 256-bit key, a 96-bit nonce and a 32-bit base block counter, then pulses `start`. Each lane builds its own 16-word state from these inputs and adds its lane index to the counter. All lanes then run the rounds in lockstep and apply the feed-forward addition. The result is four 64-byte keystream blocks, which are ready to be XORed with data by a downstream stage.

The engine runs one half of a double round per clock on every lane: the four column quarter rounds on one cycle and the four diagonal quarter rounds on the next. A complete result appears 21 cycles after the start is accepted, marked by a one-cycle `done` pulse. The outputs are registered and keep their value until the next accepted start.

Top module: `chacha4_core`

## Requirements
- R1: After an accepted start, each lane's initial state is built as follows. Words 0..3 are 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574. Words 4..11 are key bits [32k+31:32k] for k = 0..7. Word 12 is the lane counter. Words 13..15 are nonce bits [32n+31:32n] for n = 0..2.
- R2: The counter of lane i is `counter + i` modulo 2^32, so a base of 0xFFFFFFFE gives lanes 2 and 3 the counters 0 and 1.
- R3: The rounds are 10 double rounds. Each double round applies the quarter round (add, xor, rotate-left by 16, 12, 8 and 7) first to the four columns (j, j+4, j+8, j+12) and then to the four diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14).
- R4: Each output word is the final working word plus that lane's initial word, modulo 2^32, including the lane's own counter.
- R5: Lane i occupies `ks[512*i+511:512*i]`. Word j of that block is at bits [32j+31:32j] of the lane slice, so byte 4j+b of the serialized little-endian stream is bits [32j+8b+7:32j+8b].
- R6: `done` rises exactly 21 clock cycles after the edge that accepts `start`, and it is high for a single cycle.
- R7: A `start` pulse that arrives while a computation is in progress is ignored. The running result is neither restarted nor altered by the new key, nonce or counter.
- R8: After reset, `done` is 0 and `ks` is all zeros. Once a result is produced, `ks` holds it unchanged while the inputs vary, until the next accepted start completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation when idle |
| key | input | 256 | Key, word k at bits [32k+31:32k] |
| nonce | input | 96 | Nonce, word n at bits [32n+31:32n] |
| counter | input | 32 | Base block counter for lane 0 |
| ks | output | LANES*512 | Keystream blocks, lane i in slice i |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds the core with its defaults: four lanes and ten double rounds. This makes the published single-block test vector (counter 1, 96-bit nonce) directly comparable on lane 0, while lanes 1 to 3 exercise the per-lane counter offsets. Random keys, nonces and counters, together with a directed base counter of 0xFFFFFFFE, reach the modulo-2^32 counter wrap across lanes. Mid-run start pulses carrying different inputs, plus idle periods with moving inputs, cover the ignore and hold behaviour.

// File: rtl/chacha4_pkg.sv
package chacha4_pkg;
  localparam int WORD_W = 32;
  localparam int NWORDS = 16;
  localparam int BLK_W  = WORD_W * NWORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NWORDS-1:0][WORD_W-1:0] state_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } quad_t;

  localparam word_t SIGMA0 = 32'h61707865;
  localparam word_t SIGMA1 = 32'h3320646e;
  localparam word_t SIGMA2 = 32'h79622d32;
  localparam word_t SIGMA3 = 32'h6b206574;

  function automatic word_t rotl(input word_t x, input int unsigned r);
    return (x << r) | (x >> (WORD_W - r));
  endfunction

  function automatic quad_t quarter(input quad_t q);
    quad_t t;
    t = q;
    t.a = t.a + t.b; t.d = rotl(t.d ^ t.a, 16);
    t.c = t.c + t.d; t.b = rotl(t.b ^ t.c, 12);
    t.a = t.a + t.b; t.d = rotl(t.d ^ t.a, 8);
    t.c = t.c + t.d; t.b = rotl(t.b ^ t.c, 7);
    return t;
  endfunction
endpackage

// File: rtl/chacha4_halfround.sv
module chacha4_halfround
  import chacha4_pkg::*;
(
  input  state_t s_in,
  input  logic   diag,
  output state_t s_out
);
  always_comb begin
    s_out = s_in;
    for (int g = 0; g < 4; g++) begin
      int ia, ib, ic, id;
      quad_t q;
      ia = g;
      ib = diag ? 4  + ((g + 1) % 4) : 4  + g;
      ic = diag ? 8  + ((g + 2) % 4) : 8  + g;
      id = diag ? 12 + ((g + 3) % 4) : 12 + g;
      q = quarter('{a: s_in[ia], b: s_in[ib], c: s_in[ic], d: s_in[id]});
      s_out[ia] = q.a;
      s_out[ib] = q.b;
      s_out[ic] = q.c;
      s_out[id] = q.d;
    end
  end
endmodule

// File: rtl/chacha4_seq.sv
module chacha4_seq #(
  parameter int DOUBLE_ROUNDS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic diag,
  output logic finish,
  output logic done
);
  localparam int HALVES = 2 * DOUBLE_ROUNDS;
  localparam int CW     = $clog2(HALVES + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_t;
  seq_t          st;
  logic [CW-1:0] cnt;

  assign load   = (st == S_IDLE) && start;
  assign step   = (st == S_RUN);
  assign diag   = cnt[0];
  assign finish = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st  <= S_RUN;
          cnt <= '0;
        end
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(HALVES - 1)) st <= S_FIN;
        end
        S_FIN: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_after_fin_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(st) == S_FIN);
  assert_busy_no_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN) |=> (st != S_IDLE));
endmodule

// File: rtl/chacha4_lane.sv
module chacha4_lane
  import chacha4_pkg::*;
#(
  parameter int LANE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              diag,
  input  logic              finish,
  input  logic [255:0]      key,
  input  logic [95:0]       nonce,
  input  logic [31:0]       ctr_base,
  output logic [BLK_W-1:0]  ks
);
  state_t init_w, init_q, work_q, next_w, ks_q;

  always_comb begin
    init_w[0] = SIGMA0;
    init_w[1] = SIGMA1;
    init_w[2] = SIGMA2;
    init_w[3] = SIGMA3;
    for (int k = 0; k < 8; k++) init_w[4 + k] = key[32*k +: 32];
    init_w[12] = ctr_base + 32'(LANE_IDX);
    for (int n = 0; n < 3; n++) init_w[13 + n] = nonce[32*n +: 32];
  end

  chacha4_halfround u_hr (
    .s_in (work_q),
    .diag (diag),
    .s_out(next_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= '0;
      work_q <= '0;
      ks_q   <= '0;
    end else begin
      if (load) begin
        init_q <= init_w;
        work_q <= init_w;
      end else if (step) begin
        work_q <= next_w;
      end
      if (finish) begin
        for (int j = 0; j < NWORDS; j++) ks_q[j] <= work_q[j] + init_q[j];
      end
    end
  end

  assign ks = ks_q;

  assert_lane_ctr_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> init_q[12] == $past(ctr_base) + 32'(LANE_IDX));
  assert_init_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(init_q));
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(ks_q));
endmodule

// File: rtl/chacha4_core.sv
module chacha4_core
  import chacha4_pkg::*;
#(
  parameter int LANES         = 4,
  parameter int DOUBLE_ROUNDS = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [255:0]           key,
  input  logic [95:0]            nonce,
  input  logic [31:0]            counter,
  output logic [LANES*BLK_W-1:0] ks,
  output logic                   done
);
  logic load, step, diag, finish;

  chacha4_seq #(.DOUBLE_ROUNDS(DOUBLE_ROUNDS)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .diag  (diag),
    .finish(finish),
    .done  (done)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    chacha4_lane #(.LANE_IDX(i)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .step    (step),
      .diag    (diag),
      .finish  (finish),
      .key     (key),
      .nonce   (nonce),
      .ctr_base(counter),
      .ks      (ks[i*BLK_W +: BLK_W])
    );
  end

  assert_done_follows_finish_R6: assert property (@(posedge clk) disable iff (rst)
    finish |=> done);
endmodule

// File: tb/tb_chacha4_core.sv
module tb_chacha4_core;
  localparam int LANES = 4;
  localparam int BW    = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [255:0] key = '0;
  logic [95:0]  nonce = '0;
  logic [31:0]  counter = '0;
  logic [LANES*BW-1:0] ks;
  logic done;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  chacha4_core #(.LANES(LANES), .DOUBLE_ROUNDS(10)) dut (
    .clk(clk), .rst(rst), .start(start), .key(key), .nonce(nonce),
    .counter(counter), .ks(ks), .done(done)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int r);
    logic [63:0] dbl;
    dbl = {x, x} << r;
    return dbl[63:32];
  endfunction

  function automatic logic [511:0] ref_block(input logic [255:0] k,
                                             input logic [95:0] n,
                                             input logic [31:0] c);
    logic [31:0] x [16];
    logic [31:0] s0 [16];
    logic [511:0] r;
    s0[0] = 32'h61707865; s0[1] = 32'h3320646e;
    s0[2] = 32'h79622d32; s0[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) s0[4+i] = k[32*i +: 32];
    s0[12] = c;
    for (int i = 0; i < 3; i++) s0[13+i] = n[32*i +: 32];
    x = s0;
    for (int dr = 0; dr < 10; dr++) begin
      for (int g = 0; g < 8; g++) begin
        int a, b, cc, d;
        a  = g % 4;
        b  = (g < 4) ? 4 + a  : 4  + ((a + 1) % 4);
        cc = (g < 4) ? 8 + a  : 8  + ((a + 2) % 4);
        d  = (g < 4) ? 12 + a : 12 + ((a + 3) % 4);
        x[a] += x[b];  x[d] = rl(x[d] ^ x[a], 16);
        x[cc] += x[d]; x[b] = rl(x[b] ^ x[cc], 12);
        x[a] += x[b];  x[d] = rl(x[d] ^ x[a], 8);
        x[cc] += x[d]; x[b] = rl(x[b] ^ x[cc], 7);
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s0[i];
    return r;
  endfunction

  task automatic check_blk(input string req, input logic [511:0] act,
                           input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one computation; when poke is set, a start with other inputs arrives mid-run.
  task automatic run(input logic [255:0] k, input logic [95:0] n,
                     input logic [31:0] c, input bit poke);
    int cyc;
    @(negedge clk);
    key = k; nonce = n; counter = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 6) begin
        key = ~k; nonce = ~n; counter = c + 32'd77; start = 1'b1;
      end else if (poke && cyc == 7) begin
        start = 1'b0;
      end
    end
    check_int("R6 latency", cyc, 21);
    for (int i = 0; i < LANES; i++)
      check_blk(poke ? "R7 ignored start" : "R2 R3 R4 lane block",
                ks[i*BW +: BW], ref_block(k, n, c + 32'(i)));
    @(negedge clk);
    check_int("R6 single pulse", int'(done), 0);
  endtask

  logic [511:0] vec;
  logic [LANES*BW-1:0] snap;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_int("R8 reset done", int'(done), 0);
    checks++;
    if (ks !== '0) begin
      errors++;
      $display("FAIL R8 reset ks: actual nonzero expected 0");
    end

    // R1 R5: published vector on lane 0 (counter 1)
    vec = {32'h4e3c50a2, 32'he883d0cb, 32'hb94e16de, 32'hd19c12b5,
           32'ha2028bd9, 32'h05d7c214, 32'h09aa9f07, 32'h466482d2,
           32'h4e6cd4c3, 32'h9aaa2204, 32'h0368c033, 32'hc7f4d1c7,
           32'hc47120a3, 32'h1fdd0f50, 32'h15593bd1, 32'he4e7f110};
    run({32'h1f1e1d1c, 32'h1b1a1918, 32'h17161514, 32'h13121110,
         32'h0f0e0d0c, 32'h0b0a0908, 32'h07060504, 32'h03020100},
        {32'h00000000, 32'h4a000000, 32'h09000000}, 32'd1, 1'b0);
    check_blk("R1 R5 test vector lane 0", ks[0 +: BW], vec);
    checks++;
    if (ks[7:0] !== 8'h10 || ks[15:8] !== 8'hf1 || ks[511:504] !== 8'h4e) begin
      errors++;
      $display("FAIL R5 byte order: actual %h %h %h expected 10 f1 4e",
               ks[7:0], ks[15:8], ks[511:504]);
    end

    // R2 counter wrap across lanes
    run({8{$urandom()}}, {3{$urandom()}}, 32'hFFFFFFFE, 1'b0);

    // R7 start while busy
    run({8{$urandom()}}, {3{$urandom()}}, $urandom(), 1'b1);

    // R8 hold while inputs change
    snap = ks;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      key = {8{$urandom()}}; nonce = {3{$urandom()}}; counter = $urandom();
    end
    checks++;
    if (ks !== snap) begin
      errors++;
      $display("FAIL R8 hold: actual %h expected %h", ks[31:0], snap[31:0]);
    end

    // random runs
    for (int t = 0; t < 8; t++) begin
      logic [255:0] rk;
      logic [95:0] rn;
      for (int w = 0; w < 8; w++) rk[32*w +: 32] = $urandom();
      for (int w = 0; w < 3; w++) rn[32*w +: 32] = $urandom();
      run(rk, rn, $urandom(), 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule